// File: doc/BRIEF.md
# Charge Pump Gain Selection Controller

This block is the digital sequencer for a charge pump with three gain settings: 1x, 1.5x and 2x. It takes synchronous single-bit decisions from the analog side: per-sink headroom flags, a per-sink enable mask, a flag that reports the end of soft start, a standby request and a fault flag. From these it drives a gain select code, a soft-start charging enable and an output-isolate control.

When standby and fault are both released, the controller runs a soft-start phase with the pump switches open and the charging current on. It waits there until the output comparator reports that the output has charged close to the input. It then enters the regulating phase at 1x. In that phase it moves the gain one step up when any enabled sink lacks headroom, and one step down when every enabled sink has excess headroom. After every change it keeps a settle window during which no further change can happen. Standby or a fault opens the switches at once, and recovery always goes through soft start again.

Top module: `cp_gain_ctrl`

## Requirements
- R1: After reset, and while standby is requested, `gain_sel` is 00, `out_isolate` is 1 and `ss_charge` is 0.
- R2: One clock after standby and fault are both low, the block is in soft start: `ss_charge` is 1 and `out_isolate` is 1. It stays there until `ss_done` is seen.
- R3: The clock edge that samples `ss_done` high during soft start enters the regulating phase. After that edge `ss_charge` is 0, `out_isolate` is 0 and `gain_sel` is 00, and a settle window starts.
- R4: The gain code is 00 for 1x, 01 for 1.5x and 10 for 2x. In the regulating phase, with no settle window running, a low-headroom flag on any enabled sink raises the code one step at the next clock edge.
- R5: In the regulating phase, with no settle window running, no enabled sink low and every enabled sink flagging excess headroom, the code drops one step at the next clock edge.
- R6: A settle window lasts SETTLE_CYC clocks after each gain change and after entry to the regulating phase. A request that is held steady takes effect exactly SETTLE_CYC+1 clock edges after the previous change.
- R7: Flags on sinks whose enable bit is 0 are ignored. A disabled sink's low flag does not raise the gain, and a disabled sink's missing excess flag does not block a step down.
- R8: With no sink enabled, the gain holds its value and never steps up.
- R9: A step-up request at 2x and a step-down request at 1x leave the code unchanged.
- R10: One clock after standby or fault goes high, from any phase, `out_isolate` is 1, `ss_charge` is 0 and `gain_sel` is 00. After release the block goes through soft start again.
- R11: The code 11 never appears on `gain_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_req | input | 1 | 1 requests standby |
| fault | input | 1 | 1 reports a protection fault |
| ss_done | input | 1 | Output has charged close to the input |
| ch_enable | input | NUM_CH | Per-sink active mask |
| hr_low | input | NUM_CH | Sink voltage is below the step-up headroom threshold |
| hr_high | input | NUM_CH | Sink voltage is above the step-down point |
| gain_sel | output | 2 | Gain code: 00 = 1x, 01 = 1.5x, 10 = 2x |
| ss_charge | output | 1 | Soft-start charging current on |
| out_isolate | output | 1 | Pump switches open, output isolated from input |

## Verification
The bench builds the block with four sinks, a 1 MHz clock and an 8 us settle time, so the settle window is 8 clocks. This makes it possible to count the exact edge of each persistent step in both directions, and to hold requests for several windows at the 1x and 2x limits. Four sinks are enough to mix enabled and disabled channels with conflicting flags. The default 100-clock window differs only in the counter length.

// File: rtl/cp_gain_pkg.sv
package cp_gain_pkg;

  typedef enum logic [1:0] {
    G1X   = 2'b00,
    G1P5X = 2'b01,
    G2X   = 2'b10
  } gain_t;

  typedef enum logic [1:0] {
    PH_OFF  = 2'b00,
    PH_SOFT = 2'b01,
    PH_RUN  = 2'b10
  } phase_t;

  // next gain up, saturating at 2x
  function automatic gain_t gain_up(input gain_t g);
    case (g)
      G1X:     return G1P5X;
      G1P5X:   return G2X;
      default: return G2X;
    endcase
  endfunction

  // next gain down, saturating at 1x
  function automatic gain_t gain_dn(input gain_t g);
    case (g)
      G2X:     return G1P5X;
      G1P5X:   return G1X;
      default: return G1X;
    endcase
  endfunction

  // settle window length in clocks
  function automatic int settle_cycles(input int clk_mhz, input int settle_us);
    return clk_mhz * settle_us;
  endfunction

endpackage

// File: rtl/cp_headroom_eval.sv
module cp_headroom_eval #(
  parameter int NUM_CH = 9
) (
  input  logic [NUM_CH-1:0] ch_enable,
  input  logic [NUM_CH-1:0] hr_low,
  input  logic [NUM_CH-1:0] hr_high,
  output logic              any_active,
  output logic              any_low,
  output logic              all_high
);

  logic [NUM_CH-1:0] low_q;
  logic [NUM_CH-1:0] high_ok;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    // a disabled sink never asks for more gain and never blocks a step down
    assign low_q[i]   = ch_enable[i] & hr_low[i];
    assign high_ok[i] = ~ch_enable[i] | hr_high[i];
  end

  assign any_active = |ch_enable;
  assign any_low    = |low_q;
  assign all_high   = any_active & (&high_ok);

endmodule

// File: rtl/cp_settle_timer.sv
module cp_settle_timer #(
  parameter int SETTLE_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  output logic busy
);

  localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(SETTLE_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= LOAD_V;
    else if (clr)        cnt_q <= '0;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != 0);

  // R6
  settle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load && !clr) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/cp_gain_ctrl.sv
module cp_gain_ctrl
  import cp_gain_pkg::*;
#(
  parameter int NUM_CH    = 9,
  parameter int CLK_MHZ   = 1,
  parameter int SETTLE_US = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stby_req,
  input  logic              fault,
  input  logic              ss_done,
  input  logic [NUM_CH-1:0] ch_enable,
  input  logic [NUM_CH-1:0] hr_low,
  input  logic [NUM_CH-1:0] hr_high,
  output logic [1:0]        gain_sel,
  output logic              ss_charge,
  output logic              out_isolate
);

  localparam int SETTLE_CYC = settle_cycles(CLK_MHZ, SETTLE_US);

  phase_t phase_q;
  gain_t  gain_q;

  logic any_active, any_low, all_high;
  logic settle_busy;
  logic leave, run_q, run_entry, step_up_evt, step_dn_evt, gain_chg;

  cp_headroom_eval #(.NUM_CH(NUM_CH)) u_eval (
    .ch_enable (ch_enable),
    .hr_low    (hr_low),
    .hr_high   (hr_high),
    .any_active(any_active),
    .any_low   (any_low),
    .all_high  (all_high)
  );

  assign leave       = stby_req | fault;
  assign run_q       = (phase_q == PH_RUN);
  assign run_entry   = (phase_q == PH_SOFT) & ss_done & ~leave;
  assign step_up_evt = run_q & ~leave & ~settle_busy & any_low & (gain_q != G2X);
  assign step_dn_evt = run_q & ~leave & ~settle_busy & ~any_low & all_high
                       & (gain_q != G1X);
  assign gain_chg    = step_up_evt | step_dn_evt;

  cp_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (~run_q),
    .load (run_entry | gain_chg),
    .busy (settle_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OFF;
      gain_q  <= G1X;
    end else if (leave) begin
      phase_q <= PH_OFF;
      gain_q  <= G1X;
    end else begin
      case (phase_q)
        PH_OFF:  phase_q <= PH_SOFT;
        PH_SOFT: if (ss_done) begin
                   phase_q <= PH_RUN;
                   gain_q  <= G1X;
                 end
        PH_RUN:  if (step_up_evt)      gain_q <= gain_up(gain_q);
                 else if (step_dn_evt) gain_q <= gain_dn(gain_q);
        default: phase_q <= PH_OFF;
      endcase
    end
  end

  assign gain_sel    = gain_q;
  assign ss_charge   = (phase_q == PH_SOFT);
  assign out_isolate = ~run_q;

  // R11
  gain_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gain_sel != 2'b11);

  // R10
  leave_isolates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    leave |=> (out_isolate && !ss_charge && gain_sel == 2'b00));

  // R2
  charge_while_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_charge |-> out_isolate);

  // R6
  settle_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_chg && SETTLE_CYC > 0) |=> settle_busy);

  // R4
  one_step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_q) && run_q && $past(gain_q) == G1X) |-> gain_q != G2X);

  // R5
  one_step_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_q) && run_q && $past(gain_q) == G2X) |-> gain_q != G1X);

  // R8
  idle_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_q) && run_q && !$past(any_active)) |-> gain_q == $past(gain_q));

endmodule

// File: tb/tb_cp_gain_ctrl.sv
module tb_cp_gain_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 4;
  localparam int N          = 8;   // CLK_MHZ * SETTLE_US

  logic           clk = 1'b0;
  logic           rst_n;
  logic           stby_req, fault, ss_done;
  logic [NCH-1:0] ch_enable, hr_low, hr_high;
  logic [1:0]     gain_sel;
  logic           ss_charge, out_isolate;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cp_gain_ctrl #(.NUM_CH(NCH), .CLK_MHZ(1), .SETTLE_US(N)) dut (
    .clk(clk), .rst_n(rst_n), .stby_req(stby_req), .fault(fault),
    .ss_done(ss_done), .ch_enable(ch_enable), .hr_low(hr_low),
    .hr_high(hr_high), .gain_sel(gain_sel), .ss_charge(ss_charge),
    .out_isolate(out_isolate)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts edges until gain_sel moves, at most maxc
  task automatic wait_change(input int maxc, output int n);
    logic [1:0] prev = gain_sel;
    n = maxc + 1;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if (gain_sel != prev) begin n = i; break; end
    end
  endtask

  task automatic hold_gain(input string req, input int cycles, input int exp);
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (gain_sel != exp[1:0]) bad++;
    end
    check(req, bad, 0);
    check(req, gain_sel, exp);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 gain", gain_sel, 0);
    check("R1 isolate", out_isolate, 1);
    check("R1 charge", ss_charge, 0);
  endtask

  task automatic t_startup(input string req);
    stby_req = 1'b0;
    @(negedge clk);
    check({req, " R2 charge"}, ss_charge, 1);
    check({req, " R2 isolate"}, out_isolate, 1);
    repeat (3) @(negedge clk);
    check({req, " R2 still soft"}, ss_charge, 1);
    ss_done = 1'b1;
    @(negedge clk);
    ss_done = 1'b0;
    check({req, " R3 charge"}, ss_charge, 0);
    check({req, " R3 isolate"}, out_isolate, 0);
    check({req, " R3 gain"}, gain_sel, 0);
  endtask

  task automatic t_step_up;
    int n;
    ch_enable = 4'b0011; hr_low = 4'b0010; hr_high = 4'b0000;
    wait_change(4*N, n);
    check("R6 first step timing", n, N+1);
    check("R4 to 1.5x", gain_sel, 1);
    wait_change(4*N, n);
    check("R6 second step timing", n, N+1);
    check("R4 to 2x", gain_sel, 2);
    hold_gain("R9 up at 2x", 3*N, 2);
  endtask

  task automatic t_step_down;
    int n;
    // R7: ch3 disabled, low on it ignored, missing high on it ignored
    ch_enable = 4'b0011; hr_low = 4'b1000; hr_high = 4'b0011;
    wait_change(4*N, n);
    check("R5 R7 first down immediate", n, 1);
    check("R5 to 1.5x", gain_sel, 1);
    wait_change(4*N, n);
    check("R6 down timing", n, N+1);
    check("R5 to 1x", gain_sel, 0);
    hold_gain("R9 down at 1x", 3*N, 0);
    hr_high = 4'b0000;
    hold_gain("R7 disabled low ignored", 3*N, 0);
  endtask

  task automatic t_no_active;
    ch_enable = 4'b0000; hr_low = 4'b1111; hr_high = 4'b0000;
    hold_gain("R8 no active sink", 3*N, 0);
  endtask

  task automatic t_fault;
    int n;
    ch_enable = 4'b0001; hr_low = 4'b0001;
    wait_change(4*N, n);
    check("R4 up before fault", gain_sel, 1);
    fault = 1'b1;
    @(negedge clk);
    check("R10 fault isolate", out_isolate, 1);
    check("R10 fault charge", ss_charge, 0);
    check("R10 fault gain", gain_sel, 0);
    fault = 1'b0; hr_low = 4'b0000;
    @(negedge clk);
    check("R10 recovery soft start", ss_charge, 1);
    ss_done = 1'b1;
    @(negedge clk);
    ss_done = 1'b0;
    check("R10 recovery run", out_isolate, 0);
  endtask

  task automatic t_standby;
    stby_req = 1'b1;
    @(negedge clk);
    check("R10 standby isolate", out_isolate, 1);
    check("R1 standby gain", gain_sel, 0);
    repeat (5) @(negedge clk);
    check("R1 standby stays off", ss_charge, 0);
  endtask

  initial begin
    rst_n = 1'b0; stby_req = 1'b1; fault = 1'b0; ss_done = 1'b0;
    ch_enable = '0; hr_low = '0; hr_high = '0;
    t_reset();
    t_startup("start");
    t_step_up();
    t_step_down();
    t_no_active();
    t_fault();
    t_standby();
    t_startup("restart");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule